// File: doc/BRIEF.md
# Flash Write-Buffer Load Sequencer

This block sits on the synchronous write path of a NOR-style flash command interface. It watches single-cycle bus writes and recognises the buffered-program command. That command is an unlock preamble, a word-count cycle, between one and sixteen data cycles, and a confirm cycle. While the command runs, the block fills a sixteen-word staging buffer. On a valid confirm it hands the buffer, a mask of the slots that were written and the line base address to an external programming engine, and it raises a one-cycle start pulse.

Each data cycle writes the slot selected by address bits [3:0]. A violation of any sequence rule sets a sticky abort flag, which the read path presents as status bit 1. The flag stays set until the dedicated abort-reset sequence or a hardware reset. From the start pulse until the engine reports completion, the block is busy and drops every write it sees.

Unlock cycles compare only address bits [10:0] and data bits [7:0]. The command codes are:
- AAh at 555h
- 55h at 2AAh
- 25h for a buffer load
- 29h for the confirm
- F0h for the abort reset

Top module: `wbuf_load_seq`

## Requirements
- R1: After reset, start_o, busy_o and abort_o are 0.
- R2: A load is the following sequence of writes:
  - AAh at 555h, then 55h at 2AAh, then 25h at the block address;
  - a count cycle whose full 16-bit data WC is at most 15;
  - WC+1 data cycles;
  - 29h at an address whose bits [21:15] equal those of the count cycle.

  This sequence produces start_o high for exactly the one cycle after the confirm write, with busy_o high from that same cycle. base_addr_o then equals the data-cycle address with bits [3:0] cleared, and each slot s of buf_data_o (bits [16s+15:16s]) holds the data written with address bits [3:0] = s.
- R3: A count cycle with data above 15 sets abort_o.
- R4: A data cycle whose address bits [21:4] differ from those of the first data cycle sets abort_o.
- R5: Every data cycle counts toward WC+1, even one that repeats a slot. A repeated slot keeps the last value written. buf_mask_o is cleared at the count cycle and has bit s set exactly for the slots written since.
- R6: Once the WC+1 data cycles are done, a next write with low data byte other than 29h sets abort_o. This includes a surplus data cycle.
- R7: A confirm whose address bits [21:15] differ from the count cycle's sets abort_o, and start_o stays 0.
- R8: While abort_o is 1, it stays 1 and no start occurs. Only AAh at 555h, then 55h at 2AAh, then F0h at 555h clears it. A broken abort-reset preamble leaves it set.
- R9: While busy_o is 1, every write is ignored: no start, no abort and no buffer change. busy_o clears the cycle after done_i is high.
- R10: An unlock mismatch outside a load returns the sequencer to idle without setting abort_o. A following valid load then starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Write data |
| done_i | input | 1 | Programming engine finished |
| start_o | output | 1 | One-cycle start to the programming engine |
| busy_o | output | 1 | Programming in progress, writes ignored |
| abort_o | output | 1 | Sticky abort flag (status bit 1) |
| base_addr_o | output | 22 | Line base address of the loaded buffer |
| buf_data_o | output | 256 | Sixteen staged words, slot s in bits [16s+15:16s] |
| buf_mask_o | output | 16 | Slots written during the current load |

## Verification
A wrong sequencer state shows up at the latest one write later. It appears either as an abort flag that rises when it should not, or as a missing or misplaced start pulse after the confirm. A mis-tracked remaining count shows as a start one data cycle early, or as an abort on a correct confirm. A corrupted slot index or line register shows in buf_data_o, buf_mask_o or base_addr_o in the cycle the start pulse appears. A leak through the busy gate shows as a second start or an abort flag while busy_o is high.

// File: rtl/wbuf_pkg.sv
// Shared encodings for the write-buffer load sequencer.
// Assumes command codes live in data bits [7:0] and unlock addresses in bits [10:0].
package wbuf_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_UNL1, ST_UNL2, ST_COUNT, ST_LOAD, ST_CONFIRM,
        ST_ABORT, ST_ABT_UNL1, ST_ABT_UNL2
    } seq_state_e;

    localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B   = 8'h55;
    localparam logic [7:0]  CMD_BUFLOAD = 8'h25;
    localparam logic [7:0]  CMD_CONFIRM = 8'h29;
    localparam logic [7:0]  CMD_ABT_RST = 8'hF0;
    localparam logic [10:0] ADR_KEY_A   = 11'h555;
    localparam logic [10:0] ADR_KEY_B   = 11'h2AA;
endpackage

// File: rtl/wbuf_cmd_fsm.sv
// Command decoder for the buffered-program sequence.
// Tracks the unlock preamble, word count, data cycles and confirm, enforces
// every abort rule, and keeps the sticky abort flag and the busy flag.
// Assumes one write per cycle and ADDR_W > 11, BLK_LSB > log2(WORDS).
module wbuf_cmd_fsm
    import wbuf_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 16,
    parameter int BLK_LSB = 15,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = ADDR_W - IDX_W,
    localparam int BLK_W  = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_i,
    output logic              start_o,
    output logic              busy_o,
    output logic              abort_o,
    output logic              slot_we_o,
    output logic              clr_mask_o,
    output logic [ADDR_W-1:0] base_addr_o
);
    localparam logic [DATA_W-1:0] WC_MAX = DATA_W'(WORDS - 1);

    seq_state_e         state_q, state_n;
    logic               abort_q, abort_n, start_q, start_n, busy_q;
    logic               first_q, cap_cnt, line_ok, go;
    logic [BLK_W-1:0]   blk_q;
    logic [LINE_W-1:0]  line_q;
    logic [IDX_W-1:0]   left_q;
    logic [7:0]         cmd;
    logic               at_a, at_b;

    assign go      = wr_en && !busy_q;
    assign cmd     = wr_data[7:0];
    assign at_a    = (wr_addr[10:0] == ADR_KEY_A);
    assign at_b    = (wr_addr[10:0] == ADR_KEY_B);
    assign line_ok = first_q || (wr_addr[ADDR_W-1:IDX_W] == line_q);

    // Next-state decode of one accepted bus write.
    always_comb begin
        state_n   = state_q;
        abort_n   = abort_q;
        start_n   = 1'b0;
        cap_cnt   = 1'b0;
        slot_we_o = 1'b0;
        if (go) begin
            case (state_q)
                ST_IDLE:    if (cmd == CMD_KEY_A && at_a) state_n = ST_UNL1;
                ST_UNL1:    state_n = (cmd == CMD_KEY_B && at_b) ? ST_UNL2 : ST_IDLE;
                ST_UNL2:    state_n = (cmd == CMD_BUFLOAD) ? ST_COUNT : ST_IDLE;
                ST_COUNT: begin
                    if (wr_data > WC_MAX) begin
                        state_n = ST_ABORT;
                        abort_n = 1'b1;
                    end else begin
                        cap_cnt = 1'b1;
                        state_n = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (!line_ok) begin
                        state_n = ST_ABORT;
                        abort_n = 1'b1;
                    end else begin
                        slot_we_o = 1'b1;
                        if (left_q == '0) state_n = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (cmd == CMD_CONFIRM && wr_addr[ADDR_W-1:BLK_LSB] == blk_q) begin
                        start_n = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        state_n = ST_ABORT;
                        abort_n = 1'b1;
                    end
                end
                ST_ABORT:    if (cmd == CMD_KEY_A && at_a) state_n = ST_ABT_UNL1;
                ST_ABT_UNL1: state_n = (cmd == CMD_KEY_B && at_b) ? ST_ABT_UNL2 : ST_ABORT;
                ST_ABT_UNL2: begin
                    if (cmd == CMD_ABT_RST && at_a) begin
                        state_n = ST_IDLE;
                        abort_n = 1'b0;
                    end else begin
                        state_n = ST_ABORT;
                    end
                end
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    assign clr_mask_o = cap_cnt;

    // State, flags and the captured block, line and remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b0;
            start_q <= 1'b0;
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            blk_q   <= '0;
            line_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_n;
            abort_q <= abort_n;
            start_q <= start_n;
            if (start_n)     busy_q <= 1'b1;
            else if (done_i) busy_q <= 1'b0;
            if (cap_cnt) begin
                blk_q   <= wr_addr[ADDR_W-1:BLK_LSB];
                left_q  <= wr_data[IDX_W-1:0];
                first_q <= 1'b1;
            end else if (slot_we_o) begin
                first_q <= 1'b0;
                left_q  <= left_q - 1'b1;
                if (first_q) line_q <= wr_addr[ADDR_W-1:IDX_W];
            end
        end
    end

    assign start_o     = start_q;
    assign busy_o      = busy_q;
    assign abort_o     = abort_q;
    assign base_addr_o = {line_q, {IDX_W{1'b0}}};
endmodule

// File: rtl/wbuf_store.sv
// Staging buffer: one register word and one written-mask bit per slot.
// Assumes the decoder gives at most one write per cycle; the mask clears at a new load.
module wbuf_store #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_mask,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       din,
    output logic [WORDS*DATA_W-1:0] buf_o,
    output logic [WORDS-1:0]        mask_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic hit;
        assign hit = we && (idx == IDX_W'(g));

        // Hold the last word written to this slot and whether it was written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_o[g*DATA_W +: DATA_W] <= '0;
                mask_o[g]                 <= 1'b0;
            end else begin
                if (hit) buf_o[g*DATA_W +: DATA_W] <= din;
                if (clr_mask) mask_o[g] <= 1'b0;
                else if (hit) mask_o[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbuf_load_seq.sv
// Top of the write-buffer load sequencer: command decoder plus staging buffer.
// Assumes a synchronous bus with one write per cycle and an external engine that
// pulses done_i when programming ends.
module wbuf_load_seq #(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int WORDS   = 16,
    parameter int BLK_LSB = 15,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    done_i,
    output logic                    start_o,
    output logic                    busy_o,
    output logic                    abort_o,
    output logic [ADDR_W-1:0]       base_addr_o,
    output logic [WORDS*DATA_W-1:0] buf_data_o,
    output logic [WORDS-1:0]        buf_mask_o
);
    logic slot_we, clr_mask;

    wbuf_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BLK_LSB(BLK_LSB)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done_i(done_i), .start_o(start_o),
        .busy_o(busy_o), .abort_o(abort_o), .slot_we_o(slot_we),
        .clr_mask_o(clr_mask), .base_addr_o(base_addr_o)
    );

    wbuf_store #(.WORDS(WORDS), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .we(slot_we),
        .idx(wr_addr[IDX_W-1:0]), .din(wr_data),
        .buf_o(buf_data_o), .mask_o(buf_mask_o)
    );
endmodule

// File: rtl/wbuf_load_seq_chk.sv
// Port-level temporal checks for the load sequencer, attached by bind.
module wbuf_load_seq_chk #(
    parameter int WORDS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             done_i,
    input logic             start_o,
    input logic             busy_o,
    input logic             abort_o,
    input logic [WORDS-1:0] buf_mask_o
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) start_o |=> !start_o); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_o |-> busy_o); // R2
    AST_START_MASK: assert property (@(posedge clk) disable iff (!rst_n) start_o |-> (buf_mask_o != '0)); // R5
    AST_ABORT_NO_START: assert property (@(posedge clk) disable iff (!rst_n) abort_o |-> !start_o); // R8
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (abort_o && !wr_en) |=> abort_o); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> ($stable(buf_mask_o) && $stable(abort_o) && !start_o)); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !done_i) |=> busy_o); // R9
endmodule

bind wbuf_load_seq wbuf_load_seq_chk #(.WORDS(WORDS)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .done_i(done_i),
    .start_o(start_o), .busy_o(busy_o), .abort_o(abort_o),
    .buf_mask_o(buf_mask_o)
);

// File: tb/test_wbuf_load_seq.sv
module test_wbuf_load_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [21:0]  wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic         done_i = 1'b0;
    logic         start_o, busy_o, abort_o;
    logic [21:0]  base_addr_o;
    logic [255:0] buf_data_o;
    logic [15:0]  buf_mask_o;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wbuf_load_seq i_wbuf_load_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done_i(done_i), .start_o(start_o),
        .busy_o(busy_o), .abort_o(abort_o), .base_addr_o(base_addr_o),
        .buf_data_o(buf_data_o), .buf_mask_o(buf_mask_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic preamble(input logic [21:0] ba);
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
        wr(ba, 16'h0025);
    endtask

    task automatic abort_reset();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
        wr(22'h555, 16'h00F0);
    endtask

    task automatic engine_done();
        @(negedge clk); done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [17:0] line;
        logic [21:0] ba;
        logic [15:0] exp_mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start", 32'(start_o), 0);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 abort", 32'(abort_o), 0);

        // R2/R5 sweep over every word count with a scattered slot order.
        for (int wc = 0; wc < 16; wc++) begin
            line = 18'(18'h05A00 + wc * 18'h0111);
            ba = {line, 4'h0};
            exp_mask = '0;
            preamble(ba);
            wr(ba, 16'(wc));
            for (int i = 0; i <= wc; i++) begin
                int s;
                s = (i * 5 + wc) % 16;
                exp_mask[s] = 1'b1;
                wr({line, 4'(s)}, 16'(wc * 256 + i));
            end
            chk("R2 start", 32'(start_o), 0);
            wr(ba, 16'h0029);
            chk("R2 start pulse", 32'(start_o), 1);
            chk("R2 busy", 32'(busy_o), 1);
            chk("R2 base", 32'(base_addr_o), 32'(ba));
            chk("R5 mask", 32'(buf_mask_o), 32'(exp_mask));
            chk("R2 abort", 32'(abort_o), 0);
            for (int i = 0; i <= wc; i++) begin
                int s;
                s = (i * 5 + wc) % 16;
                chk("R2 slot data", 32'(buf_data_o[s*16 +: 16]), 32'(wc * 256 + i));
            end
            @(negedge clk);
            chk("R2 pulse width", 32'(start_o), 0);
            // R9: a full valid sequence and a bad count are ignored while busy.
            preamble(ba);
            wr(ba, 16'h0020);
            wr(ba, 16'h0000);
            wr(ba, 16'h0029);
            chk("R9 no start", 32'(start_o), 0);
            chk("R9 no abort", 32'(abort_o), 0);
            chk("R9 mask kept", 32'(buf_mask_o), 32'(exp_mask));
            chk("R9 still busy", 32'(busy_o), 1);
            engine_done();
            chk("R9 busy cleared", 32'(busy_o), 0);
        end

        // R5: repeated slot counts and keeps the last value.
        line = 18'h3C001; ba = {line, 4'h0};
        preamble(ba);
        wr(ba, 16'd2);
        wr({line, 4'd7}, 16'h0001);
        wr({line, 4'd7}, 16'h0002);
        wr({line, 4'd7}, 16'h0003);
        wr(ba, 16'h0029);
        chk("R5 start after repeats", 32'(start_o), 1);
        chk("R5 single mask bit", 32'(buf_mask_o), 32'h0080);
        chk("R5 last value", 32'(buf_data_o[7*16 +: 16]), 32'h0003);
        engine_done();

        // R3: word count above the maximum.
        for (int wcb = 16; wcb < 20; wcb++) begin
            preamble(ba);
            wr(ba, 16'(wcb));
            chk("R3 abort", 32'(abort_o), 1);
            // R8: valid-looking traffic and a broken reset keep the flag.
            preamble(ba);
            wr(ba, 16'd0);
            wr(ba, 16'h0000);
            wr(ba, 16'h0029);
            chk("R8 no start", 32'(start_o), 0);
            wr(22'h555, 16'h00AA);
            wr(22'h2AB, 16'h0055);
            wr(22'h555, 16'h00F0);
            chk("R8 broken reset", 32'(abort_o), 1);
            wr(22'h555, 16'h00AA);
            wr(22'h2AA, 16'h0055);
            wr(22'h554, 16'h00F0);
            chk("R8 wrong reset addr", 32'(abort_o), 1);
            abort_reset();
            chk("R8 cleared", 32'(abort_o), 0);
        end
        preamble(ba);
        wr(ba, 16'hFFFF);
        chk("R3 abort wide", 32'(abort_o), 1);
        abort_reset();

        // R4: line mismatch on a later data cycle.
        preamble(ba);
        wr(ba, 16'd3);
        wr({line, 4'd0}, 16'h1111);
        wr({line ^ 18'h1, 4'd1}, 16'h2222);
        chk("R4 abort", 32'(abort_o), 1);
        abort_reset();
        preamble(ba);
        wr(ba, 16'd3);
        wr({line, 4'd0}, 16'h1111);
        wr({line ^ 18'h20000, 4'd1}, 16'h2222);
        chk("R4 abort high bit", 32'(abort_o), 1);
        abort_reset();

        // R6: surplus data cycle and wrong confirm code.
        preamble(ba);
        wr(ba, 16'd1);
        wr({line, 4'd0}, 16'h0A0A);
        wr({line, 4'd1}, 16'h0B0B);
        wr({line, 4'd2}, 16'h0C0C);
        chk("R6 surplus abort", 32'(abort_o), 1);
        abort_reset();
        preamble(ba);
        wr(ba, 16'd0);
        wr({line, 4'd0}, 16'h0A0A);
        wr(ba, 16'h0030);
        chk("R6 wrong code abort", 32'(abort_o), 1);
        chk("R6 no start", 32'(start_o), 0);
        abort_reset();

        // R7: confirm in another block.
        preamble(ba);
        wr(ba, 16'd0);
        wr({line, 4'd0}, 16'h0A0A);
        wr(ba ^ 22'h008000, 16'h0029);
        chk("R7 abort", 32'(abort_o), 1);
        chk("R7 no start", 32'(start_o), 0);
        abort_reset();

        // R10: unlock mismatch returns quietly to idle.
        wr(22'h555, 16'h00AA);
        wr(22'h123, 16'h0055);
        chk("R10 no abort", 32'(abort_o), 0);
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
        wr(22'h555, 16'h00F0);
        chk("R10 reset outside abort", 32'(abort_o), 0);
        preamble(ba);
        wr(ba, 16'd0);
        wr({line, 4'd9}, 16'h5A5A);
        wr(ba, 16'h0029);
        chk("R10 later load starts", 32'(start_o), 1);
        chk("R10 data", 32'(buf_data_o[9*16 +: 16]), 32'h5A5A);
        engine_done();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule